// File: doc/BRIEF.md
# Tuning Telegram I2C Write Slave

This block is a receive-only I2C target that accepts tuning telegrams from a host and files each data byte into one of two destinations: a 15-bit divider-ratio register, or a set of control and port bits. SCL and SDA are sampled by the system clock. Each line passes through a synchronizer and a three-sample majority filter. Start and stop are then recognised from the filtered lines.

The address byte carries a fixed five-bit prefix and two low bits that come from a strap input. The R/W bit must be zero. After a matching address, the data bytes are handled in pairs. The top bit of the first byte of each pair selects its kind, and the second byte is taken as the same kind. A pair may be cut short by a stop or a repeated start. Every accepted byte is acknowledged by pulling SDA low during the ninth clock.

The outputs are:
- the divider value,
- the pump-current select,
- the two test bits,
- the filter-disable bit,
- seven port bits.

While reset is asserted the block never pulls SDA.

Top module: `tune_i2c_slave`

## Requirements
- R1: A start (SDA falling while SCL is high) begins address reception at any point, including in the middle of a byte. A stop (SDA rising while SCL is high) ends the telegram.
- R2: An address byte equal to 1,1,0,0,0,strap_i[1],strap_i[0] followed by a 0 R/W bit is acknowledged. The acknowledge holds sda_pull_o at 1 during the SCL-high phase of the ninth clock. Every data byte of that telegram is acknowledged the same way.
- R3: On an address mismatch or an R/W bit of 1, no acknowledge is given. The rest of the telegram, up to the next start, leaves every output unchanged.
- R4: A first-of-pair data byte with bit 7 = 0 starts a divider pair, and its bits 6..0 become div_o[14:8]. The next byte supplies div_o[7:0]. div_o is written as a whole 15-bit value when that second byte completes.
- R5: If a stop or a repeated start follows a divider first byte alone, only div_o[14:8] take the new value and div_o[7:0] keep their old value.
- R6: A first-of-pair byte with bit 7 = 1 is control byte 1. It sets:
  - pump_hi_o = bit 6
  - test_o[1] = bit 5
  - test_o[0] = bit 4
  - filt_off_o = bit 0
- R7: The byte after control byte 1 sets port_o = {bit7,bit6,bit5,bit4,bit2,bit1,bit0}. Bit 3 has no effect.
- R8: The third data byte selects its pair's kind anew, so the two pairs may arrive in either order within one telegram.
- R9: While rst_ni is low, sda_pull_o stays 0 whatever the bus does. After reset, all register outputs are 0.
- R10: A pulse on SCL that lasts one system clock is rejected by the majority filter and does not count as a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line (bus level) |
| strap_i | input | 2 | Strap-selected low address bits |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| div_o | output | 15 | Divider ratio |
| pump_hi_o | output | 1 | High pump current select |
| test_o | output | 2 | Test bits {T1,T0} |
| filt_off_o | output | 1 | Filter output disable |
| port_o | output | 7 | Port bits {P7..P4,P2..P0} |

## Verification
The hardest case to reach is a divider pair cut off after its first byte by a repeated start rather than a stop. In that case the pending high half must be committed while the next address is already arriving. Directed telegrams cover this case and also abandon a byte after three bits to force a mid-byte restart. A one-clock SCL spike is injected inside a data byte and must not shift the byte. Random telegrams then mix strap values, address mismatches, read requests, lengths of one to four bytes and both pair orders against a bench model.

// File: rtl/tune_pkg.sv
package tune_pkg;
  localparam int DIV_W  = 15;
  localparam int HI_W   = DIV_W - 8;
  localparam int PORT_W = 7;
  localparam logic [4:0] ADDR_PREFIX = 5'b11000;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA, ST_SKIP} link_st_e;
endpackage

// File: rtl/line_filter.sv
module line_filter #(
  parameter int SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  logic [SYNC_N-1:0] sync_q;
  logic [2:0]        samp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      samp_q <= '1;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], line_i};
      samp_q <= {samp_q[1:0], sync_q[SYNC_N-1]};
      line_o <= (samp_q[0] & samp_q[1]) | (samp_q[1] & samp_q[2]) | (samp_q[0] & samp_q[2]);
    end
  end

  // a flip of the majority always follows the newest sample
  assert_glitch_reject_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(line_o) |-> line_o == $past(samp_q[0]));
endmodule

// File: rtl/i2c_byte_link.sv
module i2c_byte_link
  import tune_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_f_i,
  input  logic       sda_f_i,
  input  logic [1:0] strap_i,
  output logic       byte_stb_o,
  output logic [7:0] byte_o,
  output logic       tel_end_o,
  output logic       ack_o
);
  link_st_e   st_q;
  logic       scl_d, sda_d, ack_pend_q;
  logic [3:0] cnt_q;
  logic [6:0] shreg_q;
  logic [7:0] full_byte;
  logic       scl_rise, scl_fall, start_det, stop_det;

  assign scl_rise  = scl_f_i & ~scl_d;
  assign scl_fall  = ~scl_f_i & scl_d;
  assign start_det = scl_f_i & scl_d & sda_d & ~sda_f_i;
  assign stop_det  = scl_f_i & scl_d & ~sda_d & sda_f_i;
  assign full_byte = {shreg_q, sda_f_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      scl_d      <= 1'b1;
      sda_d      <= 1'b1;
      cnt_q      <= '0;
      shreg_q    <= '0;
      ack_pend_q <= 1'b0;
      ack_o      <= 1'b0;
      byte_stb_o <= 1'b0;
      byte_o     <= '0;
      tel_end_o  <= 1'b0;
    end else begin
      scl_d      <= scl_f_i;
      sda_d      <= sda_f_i;
      byte_stb_o <= 1'b0;
      tel_end_o  <= start_det | stop_det;
      if (start_det || stop_det) begin
        st_q       <= start_det ? ST_ADDR : ST_IDLE;
        cnt_q      <= '0;
        ack_pend_q <= 1'b0;
        ack_o      <= 1'b0;
      end else if (scl_rise && st_q != ST_IDLE) begin
        if (cnt_q < 4'd8) shreg_q <= full_byte[6:0];
        if (cnt_q < 4'd9) cnt_q <= cnt_q + 4'd1;
        if (cnt_q == 4'd7) begin
          if (st_q == ST_ADDR)
            ack_pend_q <= (full_byte == {ADDR_PREFIX, strap_i, 1'b0});
          else
            ack_pend_q <= (st_q == ST_DATA);
          if (st_q == ST_DATA) begin
            byte_stb_o <= 1'b1;
            byte_o     <= full_byte;
          end
        end
      end else if (scl_fall && st_q != ST_IDLE) begin
        if (cnt_q == 4'd8 && ack_pend_q) ack_o <= 1'b1;
        if (cnt_q == 4'd9) begin
          ack_o      <= 1'b0;
          ack_pend_q <= 1'b0;
          cnt_q      <= '0;
          if (st_q == ST_ADDR) st_q <= ack_pend_q ? ST_DATA : ST_SKIP;
        end
      end
    end
  end

  assert_ack_on_low_scl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> !scl_f_i);
  assert_skip_no_ack_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SKIP) |-> !ack_o);
  assert_no_byte_outside_data_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_stb_o |-> $past(st_q) == ST_DATA);
endmodule

// File: rtl/tune_regs.sv
module tune_regs
  import tune_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_stb_i,
  input  logic [7:0]        byte_i,
  input  logic              tel_end_i,
  output logic [DIV_W-1:0]  div_o,
  output logic              pump_hi_o,
  output logic [1:0]        test_o,
  output logic              filt_off_o,
  output logic [PORT_W-1:0] port_o
);
  logic            second_q, ctl_kind_q, hi_pend_q;
  logic [HI_W-1:0] hi_buf_q;
  logic            unused_bits;

  assign unused_bits = ^byte_i[3:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      second_q   <= 1'b0;
      ctl_kind_q <= 1'b0;
      hi_pend_q  <= 1'b0;
      hi_buf_q   <= '0;
      div_o      <= '0;
      pump_hi_o  <= 1'b0;
      test_o     <= '0;
      filt_off_o <= 1'b0;
      port_o     <= '0;
    end else if (tel_end_i) begin
      second_q  <= 1'b0;
      hi_pend_q <= 1'b0;
      if (hi_pend_q) div_o[DIV_W-1:8] <= hi_buf_q;
    end else if (byte_stb_i) begin
      second_q <= ~second_q;
      if (!second_q) begin
        ctl_kind_q <= byte_i[7];
        if (!byte_i[7]) begin
          hi_buf_q  <= byte_i[HI_W-1:0];
          hi_pend_q <= 1'b1;
        end else begin
          pump_hi_o  <= byte_i[6];
          test_o     <= byte_i[5:4];
          filt_off_o <= byte_i[0];
        end
      end else if (!ctl_kind_q) begin
        div_o     <= {hi_buf_q, byte_i};
        hi_pend_q <= 1'b0;
      end else begin
        port_o <= {byte_i[7:4], byte_i[2:0]};
      end
    end
  end

  assert_div_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byte_stb_i && !tel_end_i) |=> $stable(div_o));
  assert_port_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byte_stb_i) |=> $stable(port_o));
  assert_low_kept_on_cut_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tel_end_i |=> $stable(div_o[7:0]));
endmodule

// File: rtl/tune_i2c_slave.sv
module tune_i2c_slave
  import tune_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        strap_i,
  output logic              sda_pull_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              pump_hi_o,
  output logic [1:0]        test_o,
  output logic              filt_off_o,
  output logic [PORT_W-1:0] port_o
);
  logic [1:0] raw, filt;
  logic       byte_stb, tel_end;
  logic [7:0] byte_d;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    line_filter #(.SYNC_N(SYNC_N)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (raw[g]),
      .line_o (filt[g])
    );
  end

  i2c_byte_link u_link (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_f_i    (filt[1]),
    .sda_f_i    (filt[0]),
    .strap_i    (strap_i),
    .byte_stb_o (byte_stb),
    .byte_o     (byte_d),
    .tel_end_o  (tel_end),
    .ack_o      (sda_pull_o)
  );

  tune_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .byte_stb_i (byte_stb),
    .byte_i     (byte_d),
    .tel_end_i  (tel_end),
    .div_o      (div_o),
    .pump_hi_o  (pump_hi_o),
    .test_o     (test_o),
    .filt_off_o (filt_off_o),
    .port_o     (port_o)
  );

  always_comb begin
    if (!rst_ni) assert_no_pull_in_reset_R9: assert (!sda_pull_o);
  end
endmodule

// File: tb/tune_i2c_slave_test.sv
module tune_i2c_slave_test;
  localparam int Q = 8;

  logic clk = 0, rst_ni = 0;
  logic scl_m = 1, sda_m = 1;
  logic [1:0] strap = 2'b00;
  logic sda_pull, pump_hi, filt_off;
  logic [14:0] div;
  logic [1:0] test;
  logic [6:0] port;
  logic sda_bus;

  assign sda_bus = sda_m & ~sda_pull;

  tune_i2c_slave uut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_m), .sda_i(sda_bus), .strap_i(strap),
    .sda_pull_o(sda_pull), .div_o(div), .pump_hi_o(pump_hi), .test_o(test),
    .filt_off_o(filt_off), .port_o(port)
  );

  always #5 clk = ~clk;

  int n_vec = 0, n_bad = 0;
  logic [14:0] e_div = 0;
  logic e_pump = 0, e_filt = 0;
  logic [1:0] e_test = 0;
  logic [6:0] e_port = 0;
  logic m_second = 0, m_ctl = 0, m_pend = 0;
  logic [6:0] m_hi = 0;

  task automatic chk(string tag, int got, int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_byte(logic [7:0] b);
    m_second = ~m_second;
    if (m_second) begin
      m_ctl = b[7];
      if (!b[7]) begin m_hi = b[6:0]; m_pend = 1; end
      else begin e_pump = b[6]; e_test = b[5:4]; e_filt = b[0]; end
    end else if (!m_ctl) begin
      e_div = {m_hi, b}; m_pend = 0;
    end else e_port = {b[7:4], b[2:0]};
  endtask

  task automatic m_end();
    if (m_pend) e_div[14:8] = m_hi;
    m_pend = 0; m_second = 0;
  endtask

  task automatic bus_start();
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0;
  endtask

  task automatic bus_stop();
    sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(2*Q);
  endtask

  task automatic send_bits(logic [7:0] b, int nb, bit glitch);
    for (int i = 7; i > 7 - nb; i--) begin
      tick(Q); sda_m = b[i];
      if (glitch && i == 4) begin
        tick(Q/2); scl_m = 1; tick(1); scl_m = 0; tick(Q/2 - 1);
      end else tick(Q);
      scl_m = 1; tick(2*Q); scl_m = 0;
    end
  endtask

  task automatic send_byte(logic [7:0] b, bit glitch, output logic ack);
    send_bits(b, 8, glitch);
    tick(Q); sda_m = 1; tick(Q); scl_m = 1; tick(Q);
    ack = sda_pull;
    tick(Q); scl_m = 0;
  endtask

  task automatic send_tel(string tag, logic [6:0] a7, logic rw, int n, logic [7:0] bs [4],
                          bit end_stop, bit glitch);
    logic ack;
    bit   hit;
    hit = (a7 == {5'b11000, strap}) && !rw;
    bus_start();
    send_byte({a7, rw}, 0, ack);
    chk(hit ? "R2 addr ack" : "R3 addr nack", ack, hit);
    for (int i = 0; i < n; i++) begin
      send_byte(bs[i], glitch && i == 1, ack);
      chk(hit ? "R2 data ack" : "R3 data nack", ack, hit);
      if (hit) m_byte(bs[i]);
    end
    if (hit) m_end();
    if (end_stop) bus_stop();
    if (end_stop) check_outs(tag);
  endtask

  task automatic check_outs(string tag);
    tick(10);
    chk({tag, " div"}, div, e_div);
    chk({tag, " pump"}, pump_hi, e_pump);
    chk({tag, " test"}, test, e_test);
    chk({tag, " filt"}, filt_off, e_filt);
    chk({tag, " port"}, port, e_port);
  endtask

  initial begin
    logic [7:0] bs [4];
    logic ack;
    void'($urandom(32'd7731));
    tick(3);
    chk("R9 pull in reset", sda_pull, 0);
    // a matching address driven while in reset must not be acknowledged
    bus_start();
    send_byte(8'hC0, 0, ack);
    chk("R9 no ack in reset", ack, 0);
    bus_stop();
    check_outs("R9 reset");
    rst_ni = 1;
    tick(5);

    // R4: divider pair
    bs = '{8'h2D, 8'h5A, 8'h00, 8'h00};
    send_tel("R4", 7'b1100000, 0, 2, bs, 1, 0);

    // R6 R7 R8: control pair then divider pair, strap 2
    strap = 2'b10;
    bs = '{8'hB1, 8'hFF, 8'h13, 8'h37};
    send_tel("R8", 7'b1100010, 0, 4, bs, 1, 0);
    chk("R6 pump", pump_hi, 0);
    chk("R7 port bit3 ignored", port, 7'h7F);

    // R5: lone divider byte then stop
    bs = '{8'h55, 8'h00, 8'h00, 8'h00};
    send_tel("R5 stop", 7'b1100010, 0, 1, bs, 1, 0);
    chk("R5 low kept", div, 15'h5537);

    // R3: wrong strap, then read bit
    bs = '{8'h01, 8'h02, 8'hC8, 8'h00};
    send_tel("R3 mismatch", 7'b1100011, 0, 3, bs, 1, 0);
    send_tel("R3 read", 7'b1100010, 1, 3, bs, 1, 0);

    // R5 R1: lone divider byte cut by repeated start, then control pair
    bs = '{8'h0A, 8'h00, 8'h00, 8'h00};
    send_tel("R5 restart", 7'b1100010, 0, 1, bs, 0, 0);
    bs = '{8'hE1, 8'h08, 8'h00, 8'h00};
    send_tel("R1 restart", 7'b1100010, 0, 2, bs, 1, 0);
    chk("R5 restart div", div, 15'h0A37);
    chk("R6 test bits", test, 2'b10);

    // R1: start inside a data byte after three bits
    bus_start();
    send_byte(8'hC4, 0, ack);
    chk("R1 partial addr ack", ack, 1);
    send_bits(8'hFF, 3, 0);
    bs = '{8'h12, 8'h34, 8'h00, 8'h00};
    send_tel("R1 mid-byte", 7'b1100010, 0, 2, bs, 1, 0);

    // R10: one-clock SCL spike inside the second byte
    bs = '{8'h6B, 8'hC3, 8'h00, 8'h00};
    send_tel("R10 glitch", 7'b1100010, 0, 2, bs, 1, 1);

    // random telegrams
    for (int t = 0; t < 40; t++) begin
      logic [6:0] a7;
      logic rw;
      int n;
      strap = 2'($urandom);
      a7 = ($urandom % 4 != 0) ? {5'b11000, strap} : 7'($urandom);
      rw = ($urandom % 8 == 0);
      n = 1 + $urandom % 4;
      for (int i = 0; i < 4; i++) bs[i] = 8'($urandom);
      send_tel("R8 random", a7, rw, n, bs, ($urandom % 4 != 0) || t == 39, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule